// File: doc/BRIEF.md
# Bounds-Checked Word Memory and Display Decoder

This block stands between a core's word-addressed load/store/fetch port and two storage targets: a main word memory and a small write-only character display buffer placed at a fixed high base address. Every access the core issues is decoded to one of the two targets or to neither. The block keeps a high-water mark, which is one above the highest main-memory word written so far. Reads are legal only below that mark. Writes are legal anywhere in main memory or in the display window. An illegal access is answered with a fault instead of data.

After reset the block sweeps the whole main memory and writes a recognisable filler word into every location. It then accepts a program image through a simple append-only load port, which places each word at the current mark and advances it. From then on, core requests are answered one cycle after they are accepted. A separate read port lets an external renderer fetch display characters. Each display write that commits produces a one-cycle update pulse. The default memory depth is kept small (1024 words). Setting `MEM_AW` to 16 gives the full 64K-word space at word addresses 0x0000 to 0xFFFF.

Top module: `guarded_mem_decoder`

## Requirements
- R1: After reset the mark is 0 and `ready_o` stays low for exactly 2^MEM_AW clock cycles while every main-memory word is filled. Requests and loads presented while `ready_o` is low are dropped, and no response is produced for them.
- R2: While `ready_o` is high and `req_valid_i` is low, a load (`ld_valid_i`) stores `ld_data_i` at word index equal to the mark and adds one to the mark. A load in the same cycle as a request, or with the mark already at 2^MEM_AW, is dropped.
- R3: A read (`req_we_i`=0) whose address, taken as unsigned, is below the mark is answered in the next cycle with `rsp_valid_o`=1, `rsp_fault_o`=0 and the stored word on `rsp_rdata_o`.
- R4: A read at or above the mark faults. So does a read of any address with bit 31 set (a negative address), which includes the display window. A fault shows in the next cycle as `rsp_valid_o`=1, `rsp_fault_o`=1 and `rsp_rdata_o`=0.
- R5: A write to main memory (address below 2^MEM_AW) is answered in the next cycle with `rsp_valid_o`=1, `rsp_fault_o`=0 and `rsp_rdata_o`=0. If the address is at or above the mark, the mark becomes address+1. Otherwise the mark is unchanged.
- R6: A write to an address that is neither in main memory nor in the display window faults. It stores nothing and leaves the mark unchanged.
- R7: A write to address DISP_BASE+k, with k from 0 to 63, stores the data in display slot k and leaves the mark unchanged. It raises `disp_upd_o` for exactly one cycle, together with its fault-free response.
- R8: A legal read of a main-memory word that has been neither loaded nor written returns 0xDEADBEEF.
- R9: `disp_rd_data_o` shows display slot `disp_rd_idx_i` combinationally. All slots are cleared to 0 by reset.
- R10: The mark never decreases between resets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ready_o | output | 1 | High once the post-reset fill sweep is complete |
| ld_valid_i | input | 1 | Append one program word at the mark |
| ld_data_i | input | 32 | Program word to append |
| req_valid_i | input | 1 | Core access request |
| req_we_i | input | 1 | 1 = write, 0 = read or fetch |
| req_addr_i | input | 32 | Word address |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Response to the request accepted in the previous cycle |
| rsp_fault_o | output | 1 | The request was illegal |
| rsp_rdata_o | output | 32 | Read data; 0 for writes and faults |
| disp_upd_o | output | 1 | One-cycle pulse when a display write commits |
| disp_rd_idx_i | input | 6 | Display slot to show on the renderer port |
| disp_rd_data_o | output | 32 | Content of the selected display slot |

## Verification
A wrong mark shows at the ports on the first read at its boundary. A mark that is too low makes the word just below the true bound fault. A mark that is too high lets the word at the bound return data instead of a fault. Either case is visible one cycle after that read is issued, which is why the bench probes both sides of the bound after every change to the mark. A wrong decode of the display window shows as a missing or extra `disp_upd_o` pulse in the response cycle. It also shows as a wrong slot content on the renderer port in the cycle after the write.

// File: rtl/gmd_pkg.sv
`timescale 1ns/1ps
package gmd_pkg;
    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_MEM  = 2'd1,
        TGT_DISP = 2'd2
    } tgt_e;
endpackage

// File: rtl/gmd_addr_decode.sv
`timescale 1ns/1ps
module gmd_addr_decode
    import gmd_pkg::*;
#(
    parameter int            AW        = 32,
    parameter int            MEM_AW    = 10,
    parameter int            DISP_AW   = 6,
    parameter logic [AW-1:0] DISP_BASE = 32'hF000_0000
) (
    input  logic [AW-1:0]      addr_i,
    output tgt_e               tgt_o,
    output logic [MEM_AW-1:0]  mem_idx_o,
    output logic [DISP_AW-1:0] disp_idx_o
);
    logic in_mem;
    logic in_disp;

    // Main memory: every bit above the index is zero, so negative values miss.
    assign in_mem  = (addr_i[AW-1:MEM_AW] == '0);
    // Display window: upper bits match the aligned base.
    assign in_disp = (addr_i[AW-1:DISP_AW] == DISP_BASE[AW-1:DISP_AW]);

    always_comb begin
        if (in_mem)       tgt_o = TGT_MEM;
        else if (in_disp) tgt_o = TGT_DISP;
        else              tgt_o = TGT_NONE;
    end

    assign mem_idx_o  = addr_i[MEM_AW-1:0];
    assign disp_idx_o = addr_i[DISP_AW-1:0];
endmodule

// File: rtl/gmd_word_ram.sv
`timescale 1ns/1ps
module gmd_word_ram #(
    parameter int IW = 10,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [IW-1:0] widx_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          re_i,
    input  logic [IW-1:0] ridx_i,
    output logic [DW-1:0] rdata_o
);
    localparam int DEPTH = 1 << IW;

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) cells[widx_i] <= wdata_i;
        if (re_i) rdata_o <= cells[ridx_i];
    end
endmodule

// File: rtl/gmd_disp_buf.sv
`timescale 1ns/1ps
module gmd_disp_buf #(
    parameter int IW = 6,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [IW-1:0] widx_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [IW-1:0] ridx_i,
    output logic [DW-1:0] rdata_o
);
    localparam int SLOTS = 1 << IW;

    logic [DW-1:0] slot_q [SLOTS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SLOTS; i++) slot_q[i] <= '0;
        end else if (we_i) begin
            slot_q[widx_i] <= wdata_i;
        end
    end

    assign rdata_o = slot_q[ridx_i];
endmodule

// File: rtl/guarded_mem_decoder.sv
`timescale 1ns/1ps
module guarded_mem_decoder
    import gmd_pkg::*;
#(
    parameter int            AW        = 32,
    parameter int            DW        = 32,
    parameter int            MEM_AW    = 10,
    parameter int            DISP_AW   = 6,
    parameter logic [AW-1:0] DISP_BASE = 32'hF000_0000,
    parameter logic [DW-1:0] FILL_WORD = 32'hDEAD_BEEF
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic               ready_o,
    input  logic               ld_valid_i,
    input  logic [DW-1:0]      ld_data_i,
    input  logic               req_valid_i,
    input  logic               req_we_i,
    input  logic [AW-1:0]      req_addr_i,
    input  logic [DW-1:0]      req_wdata_i,
    output logic               rsp_valid_o,
    output logic               rsp_fault_o,
    output logic [DW-1:0]      rsp_rdata_o,
    output logic               disp_upd_o,
    input  logic [DISP_AW-1:0] disp_rd_idx_i,
    output logic [DW-1:0]      disp_rd_data_o
);
    localparam int DEPTH = 1 << MEM_AW;
    localparam int MW    = MEM_AW + 1;

    typedef struct packed {
        logic [MW-1:0]     mark;
        logic              fill_busy;
        logic [MEM_AW-1:0] fill_idx;
        logic              rsp_valid;
        logic              rsp_fault;
        logic              rsp_rd;
        logic              disp_upd;
    } state_t;

    state_t st_d, st_q;

    tgt_e               tgt;
    logic [MEM_AW-1:0]  mem_idx;
    logic [DISP_AW-1:0] disp_idx;
    logic [MW-1:0]      idx_ext;
    logic               accept;

    logic               ram_we_d;
    logic [MEM_AW-1:0]  ram_widx_d;
    logic [DW-1:0]      ram_wdata_d;
    logic               ram_re_d;
    logic [DW-1:0]      ram_rdata;
    logic               disp_we_d;

    gmd_addr_decode #(
        .AW(AW), .MEM_AW(MEM_AW), .DISP_AW(DISP_AW), .DISP_BASE(DISP_BASE)
    ) u_dec (
        .addr_i     (req_addr_i),
        .tgt_o      (tgt),
        .mem_idx_o  (mem_idx),
        .disp_idx_o (disp_idx)
    );

    assign idx_ext = {1'b0, mem_idx};
    assign accept  = req_valid_i && !st_q.fill_busy;

    always_comb begin
        st_d           = st_q;
        st_d.rsp_valid = 1'b0;
        st_d.rsp_fault = 1'b0;
        st_d.rsp_rd    = 1'b0;
        st_d.disp_upd  = 1'b0;
        ram_we_d       = 1'b0;
        ram_widx_d     = mem_idx;
        ram_wdata_d    = req_wdata_i;
        ram_re_d       = 1'b0;
        disp_we_d      = 1'b0;

        if (st_q.fill_busy) begin
            ram_we_d      = 1'b1;
            ram_widx_d    = st_q.fill_idx;
            ram_wdata_d   = FILL_WORD;
            st_d.fill_idx = st_q.fill_idx + 1'b1;
            if (st_q.fill_idx == MEM_AW'(DEPTH - 1)) st_d.fill_busy = 1'b0;
        end else if (req_valid_i) begin
            st_d.rsp_valid = 1'b1;
            if (req_we_i) begin
                unique case (tgt)
                    TGT_MEM: begin
                        ram_we_d = 1'b1;
                        if (idx_ext >= st_q.mark) st_d.mark = idx_ext + MW'(1);
                    end
                    TGT_DISP: begin
                        disp_we_d     = 1'b1;
                        st_d.disp_upd = 1'b1;
                    end
                    default: st_d.rsp_fault = 1'b1;
                endcase
            end else if (tgt == TGT_MEM && idx_ext < st_q.mark) begin
                ram_re_d    = 1'b1;
                st_d.rsp_rd = 1'b1;
            end else begin
                st_d.rsp_fault = 1'b1;
            end
        end else if (ld_valid_i && st_q.mark < MW'(DEPTH)) begin
            ram_we_d    = 1'b1;
            ram_widx_d  = st_q.mark[MEM_AW-1:0];
            ram_wdata_d = ld_data_i;
            st_d.mark   = st_q.mark + MW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q           <= '0;
            st_q.fill_busy <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    gmd_word_ram #(.IW(MEM_AW), .DW(DW)) u_ram (
        .clk     (clk),
        .we_i    (ram_we_d),
        .widx_i  (ram_widx_d),
        .wdata_i (ram_wdata_d),
        .re_i    (ram_re_d),
        .ridx_i  (mem_idx),
        .rdata_o (ram_rdata)
    );

    gmd_disp_buf #(.IW(DISP_AW), .DW(DW)) u_disp (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (disp_we_d),
        .widx_i  (disp_idx),
        .wdata_i (req_wdata_i),
        .ridx_i  (disp_rd_idx_i),
        .rdata_o (disp_rd_data_o)
    );

    assign ready_o     = !st_q.fill_busy;
    assign rsp_valid_o = st_q.rsp_valid;
    assign rsp_fault_o = st_q.rsp_fault;
    assign rsp_rdata_o = st_q.rsp_rd ? ram_rdata : '0;
    assign disp_upd_o  = st_q.disp_upd;

    // R1
    fill_no_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.fill_busy |=> !rsp_valid_o);

    // R4
    read_above_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !req_we_i && tgt == TGT_MEM && idx_ext >= st_q.mark)
        |=> (rsp_valid_o && rsp_fault_o && rsp_rdata_o == '0));

    // R5
    write_raises_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_we_i && tgt == TGT_MEM && idx_ext >= st_q.mark)
        |=> (st_q.mark == $past(idx_ext) + MW'(1)));

    // R7
    disp_keeps_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_we_i && tgt == TGT_DISP) |=> $stable(st_q.mark));

    // R7
    disp_pulse_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disp_upd_o |-> (rsp_valid_o && !rsp_fault_o));

    // R10
    mark_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (st_q.mark >= $past(st_q.mark)));
endmodule

// File: tb/guarded_mem_decoder_test.sv
`timescale 1ns/1ps
module guarded_mem_decoder_test;
    localparam int MEM_AW = 10;
    localparam int DEPTH  = 1 << MEM_AW;
    localparam logic [31:0] BEEF = 32'hDEAD_BEEF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ready;
    logic        ld_valid = 1'b0;
    logic [31:0] ld_data = '0;
    logic        req_valid = 1'b0;
    logic        req_we = 1'b0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic        rsp_fault;
    logic [31:0] rsp_rdata;
    logic        disp_upd;
    logic [5:0]  disp_rd_idx = '0;
    logic [31:0] disp_rd_data;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    guarded_mem_decoder uut (
        .clk(clk), .rst_n(rst_n), .ready_o(ready),
        .ld_valid_i(ld_valid), .ld_data_i(ld_data),
        .req_valid_i(req_valid), .req_we_i(req_we), .req_addr_i(req_addr),
        .req_wdata_i(req_wdata),
        .rsp_valid_o(rsp_valid), .rsp_fault_o(rsp_fault), .rsp_rdata_o(rsp_rdata),
        .disp_upd_o(disp_upd), .disp_rd_idx_i(disp_rd_idx), .disp_rd_data_o(disp_rd_data)
    );

    typedef struct packed {
        logic        we;
        logic [31:0] addr;
        logic [31:0] wdata;
        logic        fault;
        logic [31:0] rdata;
        logic        pulse;
    } vec_t;

    // Run after loading 0x11, 0x22, 0x33 (mark = 3).
    localparam int NV = 18;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 32'h0000_0000, 32'h0,     1'b0, 32'h0000_0011, 1'b0},
        '{1'b0, 32'h0000_0002, 32'h0,     1'b0, 32'h0000_0033, 1'b0},
        '{1'b0, 32'h0000_0003, 32'h0,     1'b1, 32'h0,         1'b0},
        '{1'b0, 32'h8000_0000, 32'h0,     1'b1, 32'h0,         1'b0},
        '{1'b0, 32'hF000_0001, 32'h0,     1'b1, 32'h0,         1'b0},
        '{1'b1, 32'h0000_0010, 32'hAAAA,  1'b0, 32'h0,         1'b0},
        '{1'b0, 32'h0000_0010, 32'h0,     1'b0, 32'h0000_AAAA, 1'b0},
        '{1'b0, 32'h0000_0005, 32'h0,     1'b0, BEEF,          1'b0},
        '{1'b0, 32'h0000_0011, 32'h0,     1'b1, 32'h0,         1'b0},
        '{1'b1, 32'h0000_0003, 32'h5555,  1'b0, 32'h0,         1'b0},
        '{1'b0, 32'h0000_0003, 32'h0,     1'b0, 32'h0000_5555, 1'b0},
        '{1'b0, 32'h0000_0011, 32'h0,     1'b1, 32'h0,         1'b0},
        '{1'b1, 32'h0000_0400, 32'h1234,  1'b1, 32'h0,         1'b0},
        '{1'b1, 32'hF000_0040, 32'h1234,  1'b1, 32'h0,         1'b0},
        '{1'b1, 32'hEFFF_FFFF, 32'h1234,  1'b1, 32'h0,         1'b0},
        '{1'b1, 32'hF000_0000, 32'h41,    1'b0, 32'h0,         1'b1},
        '{1'b1, 32'hF000_003F, 32'h7A,    1'b0, 32'h0,         1'b1},
        '{1'b0, 32'h0000_0011, 32'h0,     1'b1, 32'h0,         1'b0}
    };

    function automatic string tag_of(vec_t v);
        if (v.pulse)                return "R7";
        if (v.fault && v.we)        return "R6";
        if (v.fault)                return "R4";
        if (v.we)                   return "R5";
        if (v.rdata == BEEF)        return "R8";
        return "R3";
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive at a falling edge, returns at the next falling edge with the response visible.
    task automatic do_req(input logic we, input logic [31:0] a, input logic [31:0] d);
        req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_we = 1'b0;
    endtask

    task automatic do_load(input logic [31:0] d);
        ld_valid = 1'b1; ld_data = d;
        @(negedge clk);
        ld_valid = 1'b0;
    endtask

    task automatic expect_rsp(input string tag, input logic fault, input logic [31:0] rdata,
                              input logic pulse);
        chk({tag, " valid"}, {31'b0, rsp_valid}, 32'd1);
        chk({tag, " fault"}, {31'b0, rsp_fault}, {31'b0, fault});
        chk({tag, " rdata"}, rsp_rdata, rdata);
        chk({tag, " pulse"}, {31'b0, disp_upd}, {31'b0, pulse});
    endtask

    task automatic reset_and_fill(input bool_probe);
        int c0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 ready in reset", {31'b0, ready}, 32'd0);
        chk("R1 rsp_valid in reset", {31'b0, rsp_valid}, 32'd0);
        chk("R7 pulse in reset", {31'b0, disp_upd}, 32'd0);
        disp_rd_idx = 6'd0;
        #0.1;
        chk("R9 display cleared", disp_rd_data, 32'd0);
        rst_n = 1'b1;
        c0 = cyc;
        if (bool_probe) begin
            do_req(1'b0, 32'h0, 32'h0);
            chk("R1 request ignored during fill", {31'b0, rsp_valid}, 32'd0);
            do_load(32'h9999);
        end
        while (!ready) @(negedge clk);
        chk("R1 fill length", cyc - c0, DEPTH);
    endtask

    initial begin
        reset_and_fill(1'b1);

        // R2: the load issued during the fill was dropped, so mark is still 0.
        do_req(1'b0, 32'h0, 32'h0);
        expect_rsp("R2 load during fill dropped", 1'b1, 32'h0, 1'b0);

        do_load(32'h11);
        do_load(32'h22);
        do_load(32'h33);

        for (int i = 0; i < NV; i++) begin
            do_req(VEC[i].we, VEC[i].addr, VEC[i].wdata);
            expect_rsp(tag_of(VEC[i]), VEC[i].fault, VEC[i].rdata, VEC[i].pulse);
        end

        // R7: pulse lasts one cycle only.
        do_req(1'b1, 32'hF000_0005, 32'h55);
        expect_rsp("R7 write slot 5", 1'b0, 32'h0, 1'b1);
        @(negedge clk);
        chk("R7 pulse one cycle", {31'b0, disp_upd}, 32'd0);
        chk("R3 no response when idle", {31'b0, rsp_valid}, 32'd0);

        // R9/R7: display contents at the renderer port.
        disp_rd_idx = 6'd0;  #0.1;
        chk("R9 slot 0", disp_rd_data, 32'h41);
        disp_rd_idx = 6'd63; #0.1;
        chk("R9 slot 63", disp_rd_data, 32'h7A);
        disp_rd_idx = 6'd5;  #0.1;
        chk("R7 slot 5", disp_rd_data, 32'h55);
        disp_rd_idx = 6'd1;  #0.1;
        chk("R9 slot 1 untouched", disp_rd_data, 32'h0);

        // R2: load in the same cycle as a request is dropped (mark stays 17).
        ld_valid = 1'b1; ld_data = 32'h7777;
        do_req(1'b0, 32'h0, 32'h0);
        ld_valid = 1'b0;
        expect_rsp("R3 read with concurrent load", 1'b0, 32'h11, 1'b0);
        do_req(1'b0, 32'h11, 32'h0);
        expect_rsp("R2 concurrent load dropped", 1'b1, 32'h0, 1'b0);

        // R2: a load when the request port is idle appends at the mark (17).
        do_load(32'h4242);
        do_req(1'b0, 32'h11, 32'h0);
        expect_rsp("R2 load appends at mark", 1'b0, 32'h4242, 1'b0);
        do_req(1'b0, 32'h12, 32'h0);
        expect_rsp("R4 mark after load", 1'b1, 32'h0, 1'b0);

        // R5/R10: top word raises the mark to full depth.
        do_req(1'b1, 32'h0000_03FF, 32'hCAFE);
        expect_rsp("R5 write top word", 1'b0, 32'h0, 1'b0);
        do_req(1'b0, 32'h0000_03FF, 32'h0);
        expect_rsp("R3 read top word", 1'b0, 32'hCAFE, 1'b0);
        do_req(1'b0, 32'h0000_0200, 32'h0);
        expect_rsp("R8 filler word", 1'b0, BEEF, 1'b0);
        do_req(1'b0, 32'h0000_0400, 32'h0);
        expect_rsp("R4 read past memory", 1'b1, 32'h0, 1'b0);

        // R1/R9: a second reset clears the mark and the display.
        reset_and_fill(1'b0);
        do_req(1'b0, 32'h0, 32'h0);
        expect_rsp("R1 mark cleared by reset", 1'b1, 32'h0, 1'b0);
        disp_rd_idx = 6'd63; #0.1;
        chk("R9 display cleared by reset", disp_rd_data, 32'h0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule